// File: doc/BRIEF.md
# Warp Issue Scheduler

This block chooses, on every clock cycle, at most one warp out of a pool of resident warp slots to issue its next instruction. One issue covers all 32 threads of the chosen warp at once. Each slot keeps a valid bit and a program counter. Per-warp stall events and source-readiness arrive as input vectors each cycle. A warp may issue only if its slot is valid, every source operand of its next instruction is ready, and it is not stalled. A warp that waits on a memory result shows not-ready for its dependent instruction. Sending the memory request does not stall it.

Two policies are available. Round-robin moves priority to the slot after the last granted warp after every issue. Greedy keeps granting the same warp for as long as it stays eligible. When that warp stalls, greedy falls back to the rotating search. The chosen warp is reported as a one-hot vector and as an index, together with an issue strobe and the PC being issued. The granted slot's PC then steps forward, so each warp issues strictly in program order.

Slots are filled by a launch port that writes a PC and sets the valid bit. They are emptied by a retire port.

Top module: `wsched_top`

## Requirements
- R1: After synchronous active-high reset, no slot is valid and no issue occurs. The first rotating search starts at slot 0.
- R2: A slot whose valid bit is clear is never granted.
- R3: A slot is granted only when its bit in `readyVec` is 1 and its bit in `stallVec` is 0.
- R4: In round-robin mode (`policySel`=0), the search starts at the slot after the last granted slot and wraps from NUM_WARPS-1 to 0.
- R5: When no slot is eligible, `issueValid` is 0 and the search start does not move. The next grant is taken from the same start.
- R6: In greedy mode (`policySel`=1), the last granted slot is granted again whenever it is eligible.
- R7: In greedy mode, when the last granted slot is not eligible (for example it is stalled), the grant goes to the first eligible slot after it, in wrapping order.
- R8: `issuePc` equals the granted slot's PC. After the issue, that PC grows by PC_STEP and no other slot's PC changes.
- R9: `grantOh` has exactly bit `grantId` set when `issueValid` is 1, and is all zero otherwise.
- R10: A launch sets the slot valid and loads its PC from the next cycle on. A launch takes precedence over the PC step and over a retire to the same slot in the same cycle.
- R11: A retire clears the slot's valid bit from the next cycle on. A grant made in the retire cycle still issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policySel | input | 1 | 0 selects round-robin, 1 selects greedy |
| launchEn | input | 1 | Load a slot this cycle |
| launchId | input | ID_W | Slot to load |
| launchPc | input | PC_W | Start PC for the loaded slot |
| retireEn | input | 1 | Empty a slot this cycle |
| retireId | input | ID_W | Slot to empty |
| stallVec | input | NUM_WARPS | Per-slot stall event |
| readyVec | input | NUM_WARPS | Per-slot all-sources-ready flag |
| issueValid | output | 1 | An instruction issues this cycle |
| grantId | output | ID_W | Index of the granted slot |
| grantOh | output | NUM_WARPS | One-hot grant |
| issuePc | output | PC_W | PC of the issued instruction |

## Verification
A launch or a retire can land on the very slot that is being granted in the same cycle. In that case the PC step, the valid clear and the fresh load all compete for one slot entry. The bench provokes this by pointing the launch at the slot the greedy policy holds, and by retiring slots while every warp is eligible. It then judges the next cycle's grant and `issuePc` against a model that applies the priority from R10 and R11.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  typedef enum logic {
    POL_ROUND_ROBIN = 1'b0,
    POL_GREEDY      = 1'b1
  } policy_e;

  // strobes from control to the slot table
  typedef struct packed {
    logic issue;   // granted slot steps its PC
    logic load;    // launch writes a slot
    logic clear;   // retire empties a slot
  } slotStrobe_t;

endpackage

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int ID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 policySel,
  input  logic                 launchEn,
  input  logic                 retireEn,
  input  logic [NUM_WARPS-1:0] validVec,
  input  logic [NUM_WARPS-1:0] stallVec,
  input  logic [NUM_WARPS-1:0] readyVec,
  output slotStrobe_t          strobes,
  output logic [ID_W-1:0]      grantId,
  output logic [NUM_WARPS-1:0] grantOh
);

  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_WARPS - 1);

  logic [NUM_WARPS-1:0] eligVec;
  logic [ID_W-1:0]      nextPtr;
  logic [ID_W-1:0]      lastGrant;
  logic                 haveLast;
  logic                 rrFound;
  logic [ID_W-1:0]      rrPick;
  logic                 holdOk;
  policy_e              policy;

  function automatic logic [ID_W-1:0] wrapIdx(input logic [ID_W-1:0] base, input int off);
    int sum;
    sum = int'(base) + off;
    if (sum >= NUM_WARPS) sum = sum - NUM_WARPS;
    return ID_W'(sum);
  endfunction

  assign policy  = policy_e'(policySel);
  assign eligVec = validVec & readyVec & ~stallVec;

  // rotating search from nextPtr
  always_comb begin
    rrFound = 1'b0;
    rrPick  = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (!rrFound && eligVec[wrapIdx(nextPtr, i)]) begin
        rrFound = 1'b1;
        rrPick  = wrapIdx(nextPtr, i);
      end
    end
  end

  assign holdOk = (policy == POL_GREEDY) && haveLast && eligVec[lastGrant];

  always_comb begin
    grantId       = holdOk ? lastGrant : rrPick;
    strobes.issue = holdOk || rrFound;
    strobes.load  = launchEn;
    strobes.clear = retireEn;
    grantOh       = '0;
    if (strobes.issue) grantOh[grantId] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nextPtr   <= '0;
      lastGrant <= '0;
      haveLast  <= 1'b0;
    end else if (strobes.issue) begin
      lastGrant <= grantId;
      haveLast  <= 1'b1;
      nextPtr   <= (grantId == LAST_ID) ? '0 : grantId + 1'b1;
    end
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantOh) && (strobes.issue == (grantOh != '0)));

  assert_valid_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.issue |-> validVec[grantId]);

  assert_ready_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.issue |-> (readyVec[grantId] && !stallVec[grantId]));

  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !strobes.issue |=> $stable(nextPtr));

  assert_greedy_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && policy == POL_GREEDY && $past(strobes.issue) && eligVec[$past(grantId)])
      |-> (strobes.issue && grantId == $past(grantId)));

endmodule

// File: rtl/wsched_dp.sv
module wsched_dp
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 32,
  parameter int PC_STEP   = 4,
  localparam int ID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  slotStrobe_t          strobes,
  input  logic [ID_W-1:0]      grantId,
  input  logic [ID_W-1:0]      loadId,
  input  logic [PC_W-1:0]      loadPc,
  input  logic [ID_W-1:0]      clearId,
  output logic [NUM_WARPS-1:0] validVec,
  output logic [PC_W-1:0]      issuePc
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  logic            validReg [NUM_WARPS];
  logic [PC_W-1:0] pcReg    [NUM_WARPS];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic hitLoad, hitClear, hitIssue;
    assign hitLoad  = strobes.load  && (loadId  == ID_W'(w));
    assign hitClear = strobes.clear && (clearId == ID_W'(w));
    assign hitIssue = strobes.issue && (grantId == ID_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        validReg[w] <= 1'b0;
        pcReg[w]    <= '0;
      end else if (hitLoad) begin
        validReg[w] <= 1'b1;
        pcReg[w]    <= loadPc;
      end else begin
        if (hitClear) validReg[w] <= 1'b0;
        if (hitIssue) pcReg[w]    <= pcReg[w] + STEP_V;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) validVec[w] = validReg[w];
  end

  assign issuePc = pcReg[grantId];

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.issue && !(strobes.load && loadId == grantId))
      |=> (pcReg[$past(grantId)] == $past(issuePc) + STEP_V));

  assert_launch_R10: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (validVec[$past(loadId)] && pcReg[$past(loadId)] == $past(loadPc)));

  assert_retire_R11: assert property (@(posedge clk) disable iff (rst)
    (strobes.clear && !(strobes.load && loadId == clearId)) |=> !validVec[$past(clearId)]);

endmodule

// File: rtl/wsched_top.sv
module wsched_top
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 32,
  parameter int PC_STEP   = 4,
  localparam int ID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 policySel,
  input  logic                 launchEn,
  input  logic [ID_W-1:0]      launchId,
  input  logic [PC_W-1:0]      launchPc,
  input  logic                 retireEn,
  input  logic [ID_W-1:0]      retireId,
  input  logic [NUM_WARPS-1:0] stallVec,
  input  logic [NUM_WARPS-1:0] readyVec,
  output logic                 issueValid,
  output logic [ID_W-1:0]      grantId,
  output logic [NUM_WARPS-1:0] grantOh,
  output logic [PC_W-1:0]      issuePc
);

  slotStrobe_t          strobes;
  logic [NUM_WARPS-1:0] validVec;

  wsched_ctrl #(.NUM_WARPS(NUM_WARPS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .policySel(policySel),
    .launchEn (launchEn),
    .retireEn (retireEn),
    .validVec (validVec),
    .stallVec (stallVec),
    .readyVec (readyVec),
    .strobes  (strobes),
    .grantId  (grantId),
    .grantOh  (grantOh)
  );

  wsched_dp #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W), .PC_STEP(PC_STEP)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .grantId (grantId),
    .loadId  (launchId),
    .loadPc  (launchPc),
    .clearId (retireId),
    .validVec(validVec),
    .issuePc (issuePc)
  );

  assign issueValid = strobes.issue;

endmodule

// File: tb/wsched_top_tb.sv
module wsched_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 6;
  localparam int PCW  = 16;
  localparam int STEP = 4;
  localparam int IDW  = $clog2(N);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           policySel = 1'b0;
  logic           launchEn = 1'b0;
  logic [IDW-1:0] launchId = '0;
  logic [PCW-1:0] launchPc = '0;
  logic           retireEn = 1'b0;
  logic [IDW-1:0] retireId = '0;
  logic [N-1:0]   stallVec = '0;
  logic [N-1:0]   readyVec = '0;
  logic           issueValid;
  logic [IDW-1:0] grantId;
  logic [N-1:0]   grantOh;
  logic [PCW-1:0] issuePc;

  wsched_top #(.NUM_WARPS(N), .PC_W(PCW), .PC_STEP(STEP)) u_dut (
    .clk(clk), .rst(rst), .policySel(policySel),
    .launchEn(launchEn), .launchId(launchId), .launchPc(launchPc),
    .retireEn(retireEn), .retireId(retireId),
    .stallVec(stallVec), .readyVec(readyVec),
    .issueValid(issueValid), .grantId(grantId), .grantOh(grantOh), .issuePc(issuePc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic     expValid;
    int       expId;
    logic [PCW-1:0] expPc;
    string    tag;
  } item_t;

  item_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // requirement-level model
  logic           mValid [N];
  logic [PCW-1:0] mPc    [N];
  int             mPtr  = 0;
  int             mLast = 0;
  bit             mHave = 0;

  task automatic step(input logic pol, input logic [N-1:0] stl, input logic [N-1:0] rdy,
                      input logic lEn, input int lId, input logic [PCW-1:0] lPc,
                      input logic rEn, input int rId, input string tag);
    item_t it;
    bit found;
    int g;
    @(negedge clk);
    policySel = pol; stallVec = stl; readyVec = rdy;
    launchEn = lEn; launchId = IDW'(lId); launchPc = lPc;
    retireEn = rEn; retireId = IDW'(rId);
    found = 0; g = 0;
    if (pol && mHave && mValid[mLast] && rdy[mLast] && !stl[mLast]) begin
      found = 1; g = mLast;
    end else begin
      for (int i = 0; i < N; i++) begin
        int idx;
        idx = (mPtr + i) % N;
        if (!found && mValid[idx] && rdy[idx] && !stl[idx]) begin
          found = 1; g = idx;
        end
      end
    end
    it.expValid = found;
    it.expId    = g;
    it.expPc    = mPc[g];
    it.tag      = tag;
    expQ.push_back(it);
    if (found) begin
      mPc[g] = mPc[g] + PCW'(STEP);
      mLast = g; mHave = 1; mPtr = (g + 1) % N;
    end
    if (rEn) mValid[rId] = 1'b0;
    if (lEn) begin mValid[lId] = 1'b1; mPc[lId] = lPc; end
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        item_t e;
        e = expQ.pop_front();
        check(issueValid == e.expValid, e.tag, "issueValid", int'(issueValid), int'(e.expValid));
        if (e.expValid && issueValid) begin
          check(int'(grantId) == e.expId, e.tag, "grantId", int'(grantId), e.expId);
          check(issuePc == e.expPc, {e.tag, "/R8"}, "issuePc", int'(issuePc), int'(e.expPc));
        end
        // R9: one-hot agrees with index and strobe
        check(grantOh == (issueValid ? (N'(1) << grantId) : '0), "R9", "grantOh",
              int'(grantOh), issueValid ? (1 << grantId) : 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  localparam logic [N-1:0] ALL = '1;

  initial begin
    for (int w = 0; w < N; w++) begin mValid[w] = 0; mPc[w] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: nothing valid, no issue
    step(0, '0, ALL, 0, 0, '0, 0, 0, "R1");
    step(0, '0, ALL, 0, 0, '0, 0, 0, "R1");
    // R10 launch all slots; first grant from slot 0 (R1)
    for (int w = 0; w < N; w++)
      step(0, '0, ALL, 1, w, PCW'(16'h100 * (w + 1)), 0, 0, "R10");
    // R4 rotating order with wrap
    for (int k = 0; k < 8; k++) step(0, '0, ALL, 0, 0, '0, 0, 0, "R4");
    // R3 stalls and not-ready
    for (int k = 0; k < 4; k++) step(0, 6'b000110, ALL, 0, 0, '0, 0, 0, "R3");
    for (int k = 0; k < 4; k++) step(0, '0, 6'b101111, 0, 0, '0, 0, 0, "R3");
    // R5 idle keeps the pointer
    for (int k = 0; k < 3; k++) step(0, '0, '0, 0, 0, '0, 0, 0, "R5");
    for (int k = 0; k < 2; k++) step(0, '0, ALL, 0, 0, '0, 0, 0, "R5");
    // R11 retire slot 3 while all eligible, then R2 it never wins
    step(0, '0, ALL, 0, 0, '0, 1, 3, "R11");
    for (int k = 0; k < 7; k++) step(0, '0, ALL, 0, 0, '0, 0, 0, "R2");
    // R6 greedy holds
    for (int k = 0; k < 4; k++) step(1, '0, ALL, 0, 0, '0, 0, 0, "R6");
    // R7 stall the held slot
    for (int k = 0; k < 2; k++) step(1, N'(1) << mLast, ALL, 0, 0, '0, 0, 0, "R7");
    for (int k = 0; k < 3; k++) step(1, '0, ALL, 0, 0, '0, 0, 0, "R6");
    // R10 launch over the held slot in its issue cycle
    step(1, '0, ALL, 1, mLast, 16'h0700, 0, 0, "R10");
    step(1, '0, ALL, 0, 0, '0, 0, 0, "R10");
    // R10 launch and retire on same slot: launch wins
    step(0, '0, ALL, 1, 3, 16'h0900, 1, 3, "R10");
    for (int k = 0; k < 6; k++) step(0, '0, ALL, 0, 0, '0, 0, 0, "R8");
    // R11 retire the currently held greedy slot
    step(1, '0, ALL, 0, 0, '0, 1, mLast, "R11");
    for (int k = 0; k < 3; k++) step(1, '0, ALL, 0, 0, '0, 0, 0, "R7");
    @(negedge clk);
    #(CLK_PERIOD/2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule